// File: doc/BRIEF.md
# Chainable Converter Serial Output Port

This block is the digital readout side of an 18-bit sampling converter. A rising edge on the convert input starts a conversion, and the busy output stays high for the whole of it. The analog part is replaced by a parallel result word and a conversion of fixed length. When the conversion ends, the result word is loaded into an output shift register in the same cycle that busy falls. The most significant bit appears on the serial output at once. Each later rising edge of an external serial clock moves the output on by one bit. The result is straight binary.

One input pin, the shared pin, changes role under the chain-select input. With chain select low, the shared pin is an active-low enable for the serial output. While it is deasserted, the output is released and the read position is frozen, so a read can resume where it stopped. With chain select high, the output stays driven and the shared pin is a serial input. Bits from an upstream converter enter the register at its least significant end and leave behind the local result. In this way several converters can be read through one wire.

The serial clock and the shared pin pass through a two-flop synchroniser into the system clock domain. A rising-edge detector then turns the synchronised clock into a one-cycle shift pulse.

Top module: `chain_adc_port`

## Requirements
- R1: After reset, busy is 0 and the serial output is 0.
- R2: A rising edge on conv_start while busy is 0 sets busy. Busy stays high for exactly CONV_CYCLES system clock cycles.
- R3: A rising edge on conv_start while busy is 1 is ignored. Busy still falls CONV_CYCLES cycles after the edge that started the conversion.
- R4: In the cycle busy falls, result_word is loaded. Its bit 17 (the MSB) is on sdo straight away, before any serial clock edge.
- R5: Each rising serial clock edge that is allowed to shift moves sdo to the next lower bit of the loaded result, MSB first.
- R6: sdo_oe is 1 when chain_sel is 1. When chain_sel is 0, sdo_oe is 1 exactly when shared_in is 0, and 0 (output released) when shared_in is 1.
- R7: With chain_sel 0 and shared_in 1, serial clock edges do not move the read position. After shared_in returns to 0, sdo shows the same bit it showed before.
- R8: With chain_sel 1, the value on shared_in at each serial clock edge enters the LSB. After 18 edges, the upstream bits come out on sdo MSB first, in the order they were fed.
- R9: With chain_sel 0, zeros enter the LSB, so sdo is 0 after all 18 result bits have left.
- R10: A serial clock held high for many system cycles shifts the register exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_start | input | 1 | Convert request; a rising edge starts a conversion |
| chain_sel | input | 1 | 0: shared_in is the output enable; 1: shared_in is the chain data input |
| shared_in | input | 1 | Active-low output enable, or upstream serial data |
| sclk | input | 1 | External serial clock |
| result_word | input | 18 | Parallel conversion result, straight binary |
| busy | output | 1 | High while a conversion is running |
| sdo | output | 1 | Serial data output (MSB of shift register) |
| sdo_oe | output | 1 | Output enable for the sdo pad; 0 means high impedance |

## Verification
A wrong conversion counter shows up at once as a busy pulse of the wrong length. The scoreboard also sees it one cycle later as a wrong first bit. A shift register that moves on the wrong edge, moves while disabled, or takes the wrong fill bit gives a wrong sdo value at the very next serial clock edge. The chained upstream data is checked bit by bit, so an error in the synchroniser alignment between the shared pin and the serial clock is reported within the second word.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;
  localparam int unsigned RESULT_W = 18;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_CHAIN  = 1'b1
  } port_mode_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] pin_async,
  output logic [LANES-1:0] pin_sync_o,
  output logic [LANES-1:0] pin_rise
);
  logic [LANES-1:0] stage_q [STAGES];
  logic [LANES-1:0] last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[g] <= '0;
          else        stage_q[g] <= pin_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[g] <= '0;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= stage_q[STAGES-1];
  end

  assign pin_sync_o = stage_q[STAGES-1];
  assign pin_rise   = stage_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/conv_timer.sv
module conv_timer #(
  parameter int unsigned CONV_CYCLES = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_start,
  output logic conv_rise,
  output logic busy,
  output logic conv_done
);
  localparam int unsigned CW = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

  logic          start_q;
  logic          busy_q;
  logic [CW-1:0] cnt_q;

  function automatic logic at_end(input logic [CW-1:0] c);
    return c == LAST;
  endfunction

  assign conv_rise = conv_start & ~start_q;
  assign conv_done = busy_q & at_end(cnt_q);
  assign busy      = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      busy_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      start_q <= conv_start;
      if (!busy_q) begin
        if (conv_rise) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
        end
      end else if (conv_done) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/out_shifter.sv
module out_shifter #(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         shift,
  input  logic         fill_bit,
  output logic [W-1:0] sreg,
  output logic         msb
);
  logic [W-1:0] sreg_q;

  function automatic logic [W-1:0] step_left(input logic [W-1:0] cur, input logic fill);
    return {cur[W-2:0], fill};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)      sreg_q <= '0;
    else if (load)   sreg_q <= load_word;
    else if (shift)  sreg_q <= step_left(sreg_q, fill_bit);
  end

  assign sreg = sreg_q;
  assign msb  = sreg_q[W-1];
endmodule

// File: rtl/chain_adc_port.sv
module chain_adc_port #(
  parameter int unsigned W           = adc_port_pkg::RESULT_W,
  parameter int unsigned CONV_CYCLES = 30,
  parameter int unsigned SYNC_STAGES = adc_port_pkg::SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         conv_start,
  input  logic         chain_sel,
  input  logic         shared_in,
  input  logic         sclk,
  input  logic [W-1:0] result_word,
  output logic         busy,
  output logic         sdo,
  output logic         sdo_oe
);
  import adc_port_pkg::*;

  localparam int unsigned LN_SCLK = 0;
  localparam int unsigned LN_SHR  = 1;

  port_mode_e   mode;
  logic [1:0]   pins_sync;
  logic [1:0]   pins_rise;
  logic         sclk_rise;
  logic         shr_sync;
  logic         conv_rise;
  logic         conv_done;
  logic         shift_en;
  logic         fill_bit;
  logic [W-1:0] sreg;

  assign mode = port_mode_e'(chain_sel);

  pin_sync #(.LANES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_async ({shared_in, sclk}),
    .pin_sync_o(pins_sync),
    .pin_rise  (pins_rise)
  );

  assign sclk_rise = pins_rise[LN_SCLK];
  assign shr_sync  = pins_sync[LN_SHR];

  conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_start(conv_start),
    .conv_rise (conv_rise),
    .busy      (busy),
    .conv_done (conv_done)
  );

  always_comb begin
    if (mode == MODE_CHAIN) begin
      shift_en = 1'b1;
      fill_bit = shr_sync;
    end else begin
      shift_en = ~shr_sync;
      fill_bit = 1'b0;
    end
  end

  out_shifter #(.W(W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (conv_done),
    .load_word(result_word),
    .shift    (sclk_rise & shift_en),
    .fill_bit (fill_bit),
    .sreg     (sreg),
    .msb      (sdo)
  );

  assign sdo_oe = (mode == MODE_CHAIN) | ~shared_in;
endmodule

// File: rtl/chain_adc_port_chk.sv
module chain_adc_port_chk #(
  parameter int unsigned W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic         conv_rise,
  input logic         conv_done,
  input logic         busy,
  input logic [W-1:0] result_word,
  input logic [W-1:0] sreg,
  input logic         sdo,
  input logic         shift_en,
  input logic         sclk_rise,
  input logic         chain_sel,
  input logic         shr_sync
);
  AST_BUSY_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_rise && !busy) |=> busy) else $error("busy did not rise"); // R2

  AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_done) |=> busy) else $error("busy fell early"); // R3

  AST_LOAD_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> (!busy && sdo == $past(result_word[W-1]))) else $error("msb not presented"); // R4

  AST_SHIFT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && shift_en && !conv_done) |=> (sdo == $past(sreg[W-2]))) else $error("bad shift"); // R5

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !conv_done) |=> $stable(sreg)) else $error("moved while disabled"); // R7

  AST_CHAIN_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && chain_sel && !conv_done) |=> (sreg[0] == $past(shr_sync))) else $error("chain fill"); // R8

  AST_SINGLE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> !sclk_rise) else $error("double edge"); // R10
endmodule

bind chain_adc_port chain_adc_port_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .conv_rise  (conv_rise),
  .conv_done  (conv_done),
  .busy       (busy),
  .result_word(result_word),
  .sreg       (sreg),
  .sdo        (sdo),
  .shift_en   (shift_en),
  .sclk_rise  (sclk_rise),
  .chain_sel  (chain_sel),
  .shr_sync   (shr_sync)
);

// File: tb/sim_chain_adc_port.sv
`timescale 1ns/1ps
module sim_chain_adc_port;
  localparam int W = 18;
  localparam int NCONV = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_start = 1'b0;
  logic chain_sel = 1'b0;
  logic shared_in = 1'b0;
  logic sclk = 1'b0;
  logic [W-1:0] result_word = '0;
  logic busy, sdo, sdo_oe;

  int checks = 0;
  int fails = 0;
  logic [W-1:0] mdl;

  typedef struct {
    logic  val;
    string req;
  } exp_t;
  exp_t sb[$];
  event sb_ev;

  always #4 clk = ~clk;

  chain_adc_port #(.W(W), .CONV_CYCLES(NCONV)) u0 (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .chain_sel(chain_sel),
    .shared_in(shared_in), .sclk(sclk), .result_word(result_word),
    .busy(busy), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected bits and compares them against sdo
  initial begin
    forever begin
      @(sb_ev);
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.req, {31'd0, sdo}, {31'd0, e.val});
      end
    end
  end

  function automatic void push_exp(input logic v, input string req);
    exp_t e;
    e.val = v;
    e.req = req;
    sb.push_back(e);
  endfunction

  // driver: one serial clock period; model decides what the output must show
  task automatic sclk_bit(input logic din, input logic moves, input string req, input int high_len);
    shared_in = din;
    @(negedge clk);
    sclk = 1'b1;
    repeat (high_len) @(negedge clk);
    sclk = 1'b0;
    repeat (5) @(negedge clk);
    if (moves) mdl = {mdl[W-2:0], chain_sel ? din : 1'b0};
    push_exp(mdl[W-1], req);
    -> sb_ev;
    @(negedge clk);
  endtask

  task automatic convert(input logic [W-1:0] word, input bit retrigger, input string req);
    int n;
    result_word = word;
    @(negedge clk);
    conv_start = 1'b1;
    n = 0;
    @(negedge clk);
    while (busy && n < 1000) begin
      n++;
      if (retrigger && n == 5) conv_start = 1'b0;
      if (retrigger && n == 8) conv_start = 1'b1;
      @(negedge clk);
    end
    check(req, n, NCONV);
    conv_start = 1'b0;
    mdl = word;
    push_exp(word[W-1], "R4 msb at load");
    -> sb_ev;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy reset", {31'd0, busy}, 0);
    check("R1 sdo reset", {31'd0, sdo}, 0);

    // normal mode read with pause
    chain_sel = 1'b0;
    convert(18'h2D5A3, 1'b0, "R2 busy length");
    check("R6 oe normal enabled", {31'd0, sdo_oe}, 1);
    for (int i = 0; i < 6; i++) sclk_bit(1'b0, 1'b1, "R5 msb-first shift", 4);
    shared_in = 1'b1;
    @(negedge clk);
    check("R6 oe released", {31'd0, sdo_oe}, 0);
    for (int i = 0; i < 3; i++) sclk_bit(1'b1, 1'b0, "R7 hold while disabled", 4);
    shared_in = 1'b0;
    repeat (4) @(negedge clk);
    push_exp(mdl[W-1], "R7 resume position");
    -> sb_ev;
    @(negedge clk);
    for (int i = 0; i < 11; i++) sclk_bit(1'b0, 1'b1, "R5 msb-first shift", 4);
    sclk_bit(1'b0, 1'b1, "R10 long high one shift", 40);
    for (int i = 0; i < 3; i++) sclk_bit(1'b0, 1'b1, "R9 zero fill", 4);

    // conversion retriggered while busy
    convert(18'h3FFFF, 1'b1, "R3 ignore edge while busy");
    for (int i = 0; i < 4; i++) sclk_bit(1'b0, 1'b1, "R5 all ones word", 4);

    // chain mode: local word then upstream word
    chain_sel = 1'b1;
    shared_in = 1'b1;
    @(negedge clk);
    check("R6 oe chain", {31'd0, sdo_oe}, 1);
    convert(18'h3C00F, 1'b0, "R2 busy length chain");
    begin
      logic [W-1:0] up;
      up = 18'h1A5C3;
      for (int i = 0; i < W; i++) sclk_bit(up[W-1-i], 1'b1, "R8 local bits", 4);
      for (int i = 0; i < W; i++) sclk_bit(1'b0, 1'b1, "R8 upstream bits", 4);
    end

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule